// File: doc/BRIEF.md
# Configurable External Interrupt Controller

This block watches a small group of external interrupt pins, up to four, and turns activity on them into interrupt requests toward a parent interrupt controller. Each pin has its own trigger mode: active-low level, active-high level, rising edge, falling edge, or either edge. Each pin has its own interrupt output.

All control and status sits in one 32-bit register, reached through a plain write strobe and read bus. The register is split into six equal fields of `FIELD_W` bits. Bit k of every field belongs to pin k. Software picks each pin's trigger mode with three configuration bits. It acknowledges an edge event by writing a one to the pin's clear bit, and it enables the pin's output through the mask bit.

Each pin passes through a two-flop synchronizer before detection. Edge events are latched into a status bit that holds until acknowledged. In level modes the status bit tracks the pin's active level. The interrupt output is the registered AND of status and mask.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, with all pins held high, `reg_rdata` reads 0x00F0_0000 and `irq_o` is zero. At reset every pin is in active-low level mode, its mask is zero and every other field is zero.
- R2: Register layout, counting FIELD_W=4 bit fields from bit 0:
  - field 0 (bits 3:0) is sense;
  - field 1 (bits 7:4) is status, which is read-only and ignores writes;
  - field 2 (bits 11:8) is clear, which is a write-one pulse and always reads zero;
  - field 3 (bits 15:12) is mask;
  - field 4 (bits 19:16) is both-edge;
  - field 5 (bits 23:20) is level-sense.
  Bit k of a field serves pin k, and bits 31:24 read zero.
- R3: With level-sense=0, both-edge=0 and sense=0, a 0-to-1 pin transition sets the pin's status bit. A 1-to-0 transition does not set it. A set status bit stays set after the pin returns low.
- R4: With level-sense=0, both-edge=0 and sense=1, a 1-to-0 pin transition sets the status bit and a 0-to-1 transition does not.
- R5: With level-sense=0 and both-edge=1, either transition sets the status bit, whatever the sense bit holds.
- R6: With level-sense=1, the status bit equals the pin's active level, high when sense=1 and low when sense=0, and both-edge is ignored. Writing clear has no effect on the status bit in this mode.
- R7: In edge modes, a write with a pin's clear bit at 1 clears that pin's status bit. Clear bits written as 0 leave the other pins' status bits untouched.
- R8: When an edge is detected in the same cycle as a clear write for that pin, the status bit is set after that cycle.
- R9: `irq_o[k]` equals status[k] AND mask[k] one clock after those values. A mask of 0 holds the output low.
- R10: A pin change that sets up before clock edge E0 first shows in status after edge E2, and in `irq_o` after edge E3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, current contents |
| irq_o | output | NUM_PINS | Per-pin interrupt requests to the parent controller |

## Verification
The assertions assume that a write lasts exactly one cycle. They also assume the checker sees the synchronized pin value, not the raw pin, so they say nothing about metastability in the first flop. The bench drives the pins and the write strobe only at the falling clock edge and holds each write for exactly one rising edge. Before it changes a pin's trigger mode, it lets the pins settle for several cycles, so that the detector's previous-value flop never mixes two configurations.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // Field positions inside the control/status register
  localparam int unsigned FLD_SENSE = 0;
  localparam int unsigned FLD_STAT  = 1;
  localparam int unsigned FLD_CLR   = 2;
  localparam int unsigned FLD_MASK  = 3;
  localparam int unsigned FLD_BOTH  = 4;
  localparam int unsigned FLD_LVL   = 5;
  localparam int unsigned NUM_FLDS  = 6;

  typedef enum logic [2:0] {
    TRIG_LVL_LO,
    TRIG_LVL_HI,
    TRIG_RISE,
    TRIG_FALL,
    TRIG_ANY
  } trig_e;

  // Level-sense wins over both-edge; both-edge wins over sense
  function automatic trig_e trig_decode(input logic lvl, input logic both,
                                        input logic sense);
    if (lvl)       return sense ? TRIG_LVL_HI : TRIG_LVL_LO;
    else if (both) return TRIG_ANY;
    else           return sense ? TRIG_FALL : TRIG_RISE;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/ext_irq_pin.sv
module ext_irq_pin
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cur_i,
  input  logic prev_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic lvl_i,
  input  logic clr_i,
  output logic edge_o,
  output logic stat_o
);

  trig_e mode;
  logic  edge_hit;
  logic  stat_d;
  logic  stat_q;

  assign mode = trig_decode(lvl_i, both_i, sense_i);

  always_comb begin
    edge_hit = 1'b0;
    stat_d   = stat_q;
    unique case (mode)
      TRIG_LVL_LO: stat_d = ~cur_i;
      TRIG_LVL_HI: stat_d = cur_i;
      TRIG_RISE: begin
        edge_hit = cur_i & ~prev_i;
        stat_d   = edge_hit | (stat_q & ~clr_i);
      end
      TRIG_FALL: begin
        edge_hit = ~cur_i & prev_i;
        stat_d   = edge_hit | (stat_q & ~clr_i);
      end
      TRIG_ANY: begin
        edge_hit = cur_i ^ prev_i;
        stat_d   = edge_hit | (stat_q & ~clr_i);
      end
      default: stat_d = stat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= 1'b0;
    else     stat_q <= stat_d;
  end

  assign edge_o = edge_hit;
  assign stat_o = stat_q;

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned REG_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic [NUM_PINS-1:0] stat_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic [NUM_PINS-1:0] sense_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] both_o,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] clr_o
);

  localparam int unsigned USED_W = NUM_FLDS * FIELD_W;

  logic [NUM_PINS-1:0] sense_q, mask_q, both_q, lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      mask_q  <= '0;
      both_q  <= '0;
      lvl_q   <= '1;
    end else if (we_i) begin
      sense_q <= wdata_i[FLD_SENSE*FIELD_W +: NUM_PINS];
      mask_q  <= wdata_i[FLD_MASK*FIELD_W  +: NUM_PINS];
      both_q  <= wdata_i[FLD_BOTH*FIELD_W  +: NUM_PINS];
      lvl_q   <= wdata_i[FLD_LVL*FIELD_W   +: NUM_PINS];
    end
  end

  assign clr_o = we_i ? wdata_i[FLD_CLR*FIELD_W +: NUM_PINS] : '0;

  always_comb begin
    rdata_o = '0;
    rdata_o[FLD_SENSE*FIELD_W +: NUM_PINS] = sense_q;
    rdata_o[FLD_STAT*FIELD_W  +: NUM_PINS] = stat_i;
    rdata_o[FLD_MASK*FIELD_W  +: NUM_PINS] = mask_q;
    rdata_o[FLD_BOTH*FIELD_W  +: NUM_PINS] = both_q;
    rdata_o[FLD_LVL*FIELD_W   +: NUM_PINS] = lvl_q;
  end

  assign sense_o = sense_q;
  assign mask_o  = mask_q;
  assign both_o  = both_q;
  assign lvl_o   = lvl_q;

  initial begin
    if (NUM_PINS > FIELD_W || USED_W > REG_W)
      $error("ext_irq_regs: fields do not fit the register");
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned REG_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_we,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NUM_PINS-1:0] irq_o
);

  logic [NUM_PINS-1:0] pin_cur, pin_prev;
  logic [NUM_PINS-1:0] cfg_sense, cfg_mask, cfg_both, cfg_lvl;
  logic [NUM_PINS-1:0] clr_pulse, edge_seen, stat;
  logic [NUM_PINS-1:0] irq_q;

  ext_irq_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i(pin_i),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  ext_irq_regs #(
    .NUM_PINS(NUM_PINS),
    .FIELD_W (FIELD_W),
    .REG_W   (REG_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we_i   (reg_we),
    .wdata_i(reg_wdata),
    .stat_i (stat),
    .rdata_o(reg_rdata),
    .sense_o(cfg_sense),
    .mask_o (cfg_mask),
    .both_o (cfg_both),
    .lvl_o  (cfg_lvl),
    .clr_o  (clr_pulse)
  );

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    ext_irq_pin u_pin (
      .clk    (clk),
      .rst    (rst),
      .cur_i  (pin_cur[k]),
      .prev_i (pin_prev[k]),
      .sense_i(cfg_sense[k]),
      .both_i (cfg_both[k]),
      .lvl_i  (cfg_lvl[k]),
      .clr_i  (clr_pulse[k]),
      .edge_o (edge_seen[k]),
      .stat_o (stat[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= stat & cfg_mask;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int unsigned NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] cur,
  input logic [NUM_PINS-1:0] edge_seen,
  input logic [NUM_PINS-1:0] clr,
  input logic [NUM_PINS-1:0] lvl,
  input logic [NUM_PINS-1:0] sense,
  input logic [NUM_PINS-1:0] mask,
  input logic [NUM_PINS-1:0] stat,
  input logic [NUM_PINS-1:0] irq
);

  // R9: output is registered status AND mask
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(stat & mask));

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_chk
    // R6: active-high level tracks the synchronized pin
    a_r6_level_high: assert property (@(posedge clk) disable iff (rst)
      (lvl[k] && sense[k]) |=> stat[k] == $past(cur[k]));
    // R6: active-low level tracks the inverted pin
    a_r6_level_low: assert property (@(posedge clk) disable iff (rst)
      (lvl[k] && !sense[k]) |=> stat[k] == !$past(cur[k]));
    // R3: latched edge event holds without a clear
    a_r3_edge_holds: assert property (@(posedge clk) disable iff (rst)
      (!lvl[k] && stat[k] && !clr[k]) |=> stat[k]);
    // R7: clear without a new edge empties the status
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (!lvl[k] && !edge_seen[k] && clr[k]) |=> !stat[k]);
    // R8: an edge always sets status, even alongside a clear
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
      (!lvl[k] && edge_seen[k]) |=> stat[k]);
  end

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cur      (pin_cur),
  .edge_seen(edge_seen),
  .clr      (clr_pulse),
  .lvl      (cfg_lvl),
  .sense    (cfg_sense),
  .mask     (cfg_mask),
  .stat     (stat),
  .irq      (irq_o)
);

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;

  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pins = 4'hF;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ext_irq_ctrl #(.NUM_PINS(NP), .FIELD_W(4), .REG_W(32)) u_ext_irq_ctrl (
    .clk(clk), .rst(rst), .pin_i(pins), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] mk(input logic [3:0] sense, input logic [3:0] clr,
                                     input logic [3:0] mask, input logic [3:0] both,
                                     input logic [3:0] lvl);
    return {8'h00, lvl, both, mask, clr, 4'h0, sense};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] st();
    return rdata[7:4];
  endfunction

  task automatic t_reset();
    chk("R1 reset rdata", rdata, 32'h00F0_0000);
    chk("R1 reset irq", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFF5 & 32'h0000_FFFF);
    settle();
    chk("R2 layout/status ignored/clear reads 0", rdata, 32'h0000_F005);
    chk("R2 upper bits zero", {24'h0, rdata[31:24]}, 32'h0);
  endtask

  task automatic t_rise();
    wr(mk(4'h0, 4'hF, 4'hF, 4'h0, 4'h0));
    settle();
    pins[0] = 1'b0; settle();
    chk("R3 fall ignored in rise mode", {28'h0, st()}, 32'h0);
    pins[0] = 1'b1; settle();
    chk("R3 rise sets status", {28'h0, st()}, 32'h1);
    pins[0] = 1'b0; settle();
    chk("R3 status held", {28'h0, st()}, 32'h1);
    chk("R9 irq on masked-in status", {28'h0, irq}, 32'h1);
    wr(mk(4'h0, 4'h2, 4'hF, 4'h0, 4'h0));
    settle();
    chk("R7 clear of other pin leaves status", {28'h0, st()}, 32'h1);
    wr(mk(4'h0, 4'h1, 4'hF, 4'h0, 4'h0));
    settle();
    chk("R7 clear removes status", {28'h0, st()}, 32'h0);
    chk("R7 irq dropped", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_fall();
    pins = 4'hF;
    wr(mk(4'hF, 4'hF, 4'hF, 4'h0, 4'h0));
    settle();
    pins[1] = 1'b0; settle();
    chk("R4 fall sets status", {28'h0, st()}, 32'h2);
    wr(mk(4'hF, 4'hF, 4'hF, 4'h0, 4'h0));
    pins[1] = 1'b1; settle();
    chk("R4 rise ignored in fall mode", {28'h0, st()}, 32'h0);
  endtask

  task automatic t_both();
    wr(mk(4'h5, 4'hF, 4'hF, 4'hF, 4'h0));
    settle();
    pins[2] = 1'b0; settle();
    chk("R5 falling edge in any mode", {28'h0, st()}, 32'h4);
    wr(mk(4'h5, 4'hF, 4'hF, 4'hF, 4'h0));
    settle();
    chk("R5 cleared", {28'h0, st()}, 32'h0);
    pins[2] = 1'b1; settle();
    chk("R5 rising edge in any mode", {28'h0, st()}, 32'h4);
    wr(mk(4'h5, 4'hF, 4'hF, 4'hF, 4'h0));
    settle();
  endtask

  task automatic t_level();
    pins = 4'b0011;
    wr(mk(4'b1010, 4'h0, 4'hF, 4'hF, 4'hF));
    settle();
    chk("R6 mixed polarity levels", {28'h0, st()}, 32'h6);
    wr(mk(4'b1010, 4'hF, 4'hF, 4'hF, 4'hF));
    settle();
    chk("R6 clear has no effect in level mode", {28'h0, st()}, 32'h6);
    pins = 4'b1100; settle();
    chk("R6 status follows level", {28'h0, st()}, 32'h9);
  endtask

  task automatic t_mask();
    @(negedge clk); we = 1'b1; wdata = mk(4'b1010, 4'h0, 4'h0, 4'h0, 4'hF);
    @(negedge clk); we = 1'b0; wdata = '0;
    @(negedge clk);
    chk("R9 mask 0 suppresses", {28'h0, irq}, 32'h0);
    @(negedge clk); we = 1'b1; wdata = mk(4'b1010, 4'h0, 4'h1, 4'h0, 4'hF);
    @(negedge clk); we = 1'b0; wdata = '0;
    chk("R9 irq one clock after mask", {28'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq follows mask", {28'h0, irq}, 32'h1);
  endtask

  task automatic t_latency();
    pins = 4'h0;
    wr(mk(4'h0, 4'hF, 4'hF, 4'h0, 4'h0));
    settle();
    wr(mk(4'h0, 4'hF, 4'hF, 4'h0, 4'h0));
    settle();
    @(negedge clk); pins[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 status not yet after E1", {28'h0, st()}, 32'h0);
    @(negedge clk);
    chk("R10 status after E2", {28'h0, st()}, 32'h8);
    chk("R10 irq not yet after E2", {28'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq after E3", {28'h0, irq}, 32'h8);
  endtask

  task automatic t_race();
    wr(mk(4'h0, 4'hF, 4'hF, 4'h0, 4'h0));
    settle();
    pins[0] = 1'b1; settle();
    pins[0] = 1'b0; settle();
    chk("R8 precondition status set", {28'h0, 3'b0, st()[0]}, 32'h1);
    @(negedge clk); pins[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; wdata = mk(4'h0, 4'h1, 4'hF, 4'h0, 4'h0);
    @(negedge clk); we = 1'b0; wdata = '0;
    settle();
    chk("R8 edge wins over clear", {28'h0, 3'b0, st()[0]}, 32'h1);
    wr(mk(4'h0, 4'h1, 4'hF, 4'h0, 4'h0));
    settle();
    chk("R7 clear alone removes", {28'h0, 3'b0, st()[0]}, 32'h0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    settle();
    t_reset();
    t_layout();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_mask();
    t_latency();
    t_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule